// File: doc/BRIEF.md
# Single-Driver Pending Event Scheduler

This block models the output driver of one simulated signal as clocked hardware. It keeps a short list of future assignments, each a four-state value paired with an absolute due time, sorted so that the earliest is at the head. A free-running time count comes in from outside. On every clock edge the head event is applied if its due time has been reached. The applied value becomes the driver output, and a strobe marks a real change of value.

New assignments arrive as requests. Each carries a value, an absolute due time and a delay-mode bit. Before a new event is stored, the pending list is pruned. In transport mode only the events due after the new one are discarded, so every pulse passes through. In inertial mode, events due earlier than the new one are also discarded unless they carry the same value, so a pulse shorter than the delay never reaches the output. When the pruned list has no free slot, the request is refused and an overflow flag is raised for one cycle.

Top module: `drv_event_queue`

## Requirements
- R1: While `rst` is high and after it is released, the driver value is unknown (code 2'b10), and `drv_change` and `overflow` are 0. Values are coded 0=2'b00, 1=2'b01, unknown=2'b10, high impedance=2'b11.
- R2: The pending list starts empty after reset, so the driver value stays unknown until an event is applied.
- R3: A stored event is applied at the first clock edge at which the sampled `now_i` is greater than or equal to its due time. `drv_value` shows the applied value right after that edge.
- R4: A request whose due time equals the current `now_i` is stored at that edge and applied at the next edge, never in the same cycle.
- R5: Pending events stay in ascending due-time order. In transport mode (`req_inertial`=0), every pending event due strictly later than the new due time is discarded before the new event is stored.
- R6: In inertial mode (`req_inertial`=1), later events are discarded as in R5. Events due strictly earlier whose value differs from the new value are also discarded. Earlier events with an equal value are kept.
- R7: In transport mode a pulse of any length is reproduced on `drv_value`. In inertial mode a pulse shorter than the second request's delay is swallowed and does not appear.
- R8: If no slot is free after pruning, the request is refused and the stored events are unchanged. `overflow` is high for exactly the cycle after that edge.
- R9: `drv_change` is high for one cycle exactly when the applied value differs from the previous driver value. Applying an equal value gives no strobe.
- R10: When the head event fires in the same cycle as a request, the head is applied first, and pruning and insertion act on the remaining events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | TW | Current time count |
| req_valid | input | 1 | Schedule request present this cycle |
| req_value | input | 2 | Four-state value to schedule |
| req_due | input | TW | Absolute due time of the request |
| req_inertial | input | 1 | 1 selects inertial pruning, 0 selects transport |
| drv_value | output | 2 | Current driver value |
| drv_change | output | 1 | One-cycle pulse on a change of driver value |
| overflow | output | 1 | One-cycle pulse when a request is refused |

## Verification
The same two-request pulse is sent once in transport mode and once in inertial mode. The outputs differ only in whether the short pulse survives, which separates the two pruning rules. Further pairs are then applied: a late event followed by an earlier one, two inertial events with equal values, and a zero-delay request. These distinguish deletion of later events, retention of equal-valued earlier events, and the one-cycle minimum latency. A burst of ascending requests fills the list, and the refused request, followed by a drain, shows that a refusal leaves the stored events intact. A request timed to meet a firing head shows the order between applying and pruning.

// File: rtl/drv_evq_pkg.sv
`timescale 1ns/1ps
package drv_evq_pkg;
  typedef logic [1:0] fs_t;
  localparam fs_t FS_0 = 2'b00;
  localparam fs_t FS_1 = 2'b01;
  localparam fs_t FS_X = 2'b10;
  localparam fs_t FS_Z = 2'b11;
endpackage

// File: rtl/evq_filter.sv
`timescale 1ns/1ps
// Prunes the pending list for a new request and packs survivors to the low slots.
module evq_filter
  import drv_evq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][1:0]    in_val,
  input  logic [DEPTH-1:0][TW-1:0] in_due,
  input  logic [CW-1:0]            in_cnt,
  input  fs_t                      new_val,
  input  logic [TW-1:0]            new_due,
  input  logic                     inertial,
  output logic [DEPTH-1:0][1:0]    out_val,
  output logic [DEPTH-1:0][TW-1:0] out_due,
  output logic [CW-1:0]            out_cnt
);
  logic [DEPTH-1:0] keep;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = (CW'(i) < in_cnt) && (in_due[i] <= new_due) &&
                !(inertial && (in_due[i] < new_due) && (in_val[i] != new_val));
    end
  end

  // Walk from the top so survivors end up packed at low slots in order.
  always_comb begin
    out_val = '0;
    out_due = '0;
    out_cnt = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (keep[i]) begin
        out_val    = out_val << 2;
        out_due    = out_due << TW;
        out_val[0] = in_val[i];
        out_due[0] = in_due[i];
        out_cnt    = out_cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/evq_out_stage.sv
`timescale 1ns/1ps
// Registered driver value and change strobe.
module evq_out_stage
  import drv_evq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  fs_t  head_val,
  output fs_t  value,
  output logic change
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value  <= FS_X;
      change <= 1'b0;
    end else begin
      change <= fire && (head_val != value);
      if (fire) value <= head_val;
    end
  end
endmodule

// File: rtl/drv_event_queue.sv
`timescale 1ns/1ps
module drv_event_queue
  import drv_evq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] now_i,
  input  logic          req_valid,
  input  logic [1:0]    req_value,
  input  logic [TW-1:0] req_due,
  input  logic          req_inertial,
  output logic [1:0]    drv_value,
  output logic          drv_change,
  output logic          overflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][1:0]    q_val;
  logic [DEPTH-1:0][TW-1:0] q_due;
  logic [CW-1:0]            q_count;

  logic                     head_fire;
  logic [DEPTH-1:0][1:0]    pp_val, kept_val, nxt_val;
  logic [DEPTH-1:0][TW-1:0] pp_due, kept_due, nxt_due;
  logic [CW-1:0]            pp_cnt, kept_cnt, nxt_cnt;
  logic                     full, accept;

  // Head leaves the list first, then pruning sees the remainder.
  assign head_fire = (q_count != '0) && (q_due[0] <= now_i);
  assign pp_val    = head_fire ? (q_val >> 2)  : q_val;
  assign pp_due    = head_fire ? (q_due >> TW) : q_due;
  assign pp_cnt    = q_count - CW'(head_fire);

  evq_filter #(.DEPTH(DEPTH), .TW(TW)) u_filter (
    .in_val   (pp_val),
    .in_due   (pp_due),
    .in_cnt   (pp_cnt),
    .new_val  (req_value),
    .new_due  (req_due),
    .inertial (req_inertial),
    .out_val  (kept_val),
    .out_due  (kept_due),
    .out_cnt  (kept_cnt)
  );

  assign full   = (kept_cnt == CW'(DEPTH));
  assign accept = req_valid && !full;

  // Pruning removed every later event, so the new one always goes last.
  always_comb begin
    if (accept) begin
      nxt_val = kept_val;
      nxt_due = kept_due;
      for (int j = 0; j < DEPTH; j++) begin
        if (CW'(j) == kept_cnt) begin
          nxt_val[j] = req_value;
          nxt_due[j] = req_due;
        end
      end
      nxt_cnt = kept_cnt + CW'(1);
    end else begin
      nxt_val = pp_val;
      nxt_due = pp_due;
      nxt_cnt = pp_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_val    <= '0;
      q_due    <= '0;
      q_count  <= '0;
      overflow <= 1'b0;
    end else begin
      q_val    <= nxt_val;
      q_due    <= nxt_due;
      q_count  <= nxt_count_sel(nxt_cnt);
      overflow <= req_valid && full;
    end
  end

  function automatic logic [CW-1:0] nxt_count_sel(input logic [CW-1:0] c);
    return c;
  endfunction

  evq_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (head_fire),
    .head_val (q_val[0]),
    .value    (drv_value),
    .change   (drv_change)
  );
endmodule

// File: rtl/drv_event_queue_chk.sv
`timescale 1ns/1ps
module drv_event_queue_chk #(
  parameter int DEPTH = 4,
  parameter int TW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic [1:0]               drv_value,
  input logic                     drv_change,
  input logic                     overflow,
  input logic [CW-1:0]            q_count,
  input logic [DEPTH-1:0][TW-1:0] q_due
);
  assert_strobe_means_change_R9: assert property (@(posedge clk) disable iff (rst)
    drv_change |-> (drv_value != $past(drv_value)));

  assert_change_gives_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    (drv_value != $past(drv_value)) |-> drv_change);

  assert_overflow_only_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(req_valid) && ($past(q_count) == CW'(DEPTH))));

  assert_refusal_keeps_events_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ((q_due == $past(q_due)) && (q_count == $past(q_count))));

  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_order
    assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
      (CW'(i + 1) < q_count) |-> (q_due[i] <= q_due[i+1]));
  end
endmodule

bind drv_event_queue drv_event_queue_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .drv_value  (drv_value),
  .drv_change (drv_change),
  .overflow   (overflow),
  .q_count    (q_count),
  .q_due      (q_due)
);

// File: tb/drv_event_queue_tb.sv
`timescale 1ns/1ps
module drv_event_queue_tb;
  import drv_evq_pkg::*;
  localparam int DEPTH = 4;
  localparam int TW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] now_i = '0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_value = 2'b00;
  logic [TW-1:0] req_due = '0;
  logic          req_inertial = 1'b0;
  logic [1:0]    drv_value;
  logic          drv_change;
  logic          overflow;

  always #2 clk = ~clk;

  drv_event_queue #(.DEPTH(DEPTH), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .now_i(now_i), .req_valid(req_valid),
    .req_value(req_value), .req_due(req_due), .req_inertial(req_inertial),
    .drv_value(drv_value), .drv_change(drv_change), .overflow(overflow)
  );

  typedef struct { logic [1:0] v; int unsigned d; } ev_t;
  typedef struct { logic [1:0] v; logic ch; logic ov; string tag; } exp_t;

  ev_t         mq[$];
  exp_t        exp_q[$];
  int unsigned tnow = 0;
  logic [1:0]  cur = FS_X;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0d", tag, what, act, expv, tnow);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes what the outputs must show.
  task automatic step(input bit vld, input logic [1:0] v, input int unsigned dly,
                      input bit inert, input string tag);
    ev_t         kept[$];
    logic [1:0]  nv;
    bit          ch, ov;
    int unsigned due;
    due = tnow + dly;
    @(negedge clk);
    now_i = tnow; req_valid = vld; req_value = v; req_due = due; req_inertial = inert;
    nv = cur; ch = 0; ov = 0;
    if (mq.size() > 0 && mq[0].d <= tnow) begin
      ch = (mq[0].v != cur);
      nv = mq[0].v;
      void'(mq.pop_front());
    end
    if (vld) begin
      foreach (mq[i])
        if (mq[i].d <= due && !(inert && mq[i].d < due && mq[i].v != v))
          kept.push_back(mq[i]);
      if (kept.size() == DEPTH) ov = 1;
      else begin
        kept.push_back('{v, due});
        mq = kept;
      end
    end
    cur = nv;
    exp_q.push_back('{nv, ch, ov, tag});
    tnow++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, FS_0, 0, 0, tag);
  endtask

  // Monitor: compares each cycle's outputs with the scoreboard entry.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      #1;
      e = exp_q.pop_front();
      check(e.tag, "drv_value", int'(drv_value), int'(e.v));
      check(e.tag, "drv_change", int'(drv_change), int'(e.ch));
      check(e.tag, "overflow", int'(overflow), int'(e.ov));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "drv_value in reset", int'(drv_value), int'(FS_X));
    check("R1", "drv_change in reset", int'(drv_change), 0);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "overflow after reset", int'(overflow), 0);
    idle(3, "R2");                              // empty list: value stays unknown
    step(1, FS_1, 3, 0, "R3"); idle(5, "R3");   // applied when time reaches due
    step(1, FS_0, 0, 0, "R4"); idle(3, "R4");   // zero delay lands one edge later
    step(1, FS_1, 4, 0, "R7"); step(1, FS_0, 5, 0, "R7"); idle(8, "R7"); // transport pulse kept
    step(1, FS_1, 4, 1, "R7"); step(1, FS_0, 5, 1, "R7"); idle(8, "R9"); // inertial pulse gone, no strobe
    step(1, FS_Z, 3, 1, "R6"); step(1, FS_Z, 5, 1, "R6"); idle(7, "R6"); // equal value retained
    step(1, FS_1, 8, 0, "R5"); step(1, FS_0, 2, 0, "R5"); idle(10, "R5"); // later event dropped
    step(1, FS_X, 8, 1, "R6"); step(1, FS_1, 3, 1, "R6"); idle(10, "R6"); // inertial drops later too
    step(1, FS_0, 2, 0, "R10"); idle(1, "R10");
    step(1, FS_1, 5, 0, "R10"); idle(7, "R10");                          // head fires with request
    step(1, FS_0, 10, 0, "R8"); step(1, FS_1, 10, 0, "R8");
    step(1, FS_0, 10, 0, "R8"); step(1, FS_1, 10, 0, "R8");
    step(1, FS_Z, 10, 0, "R8"); idle(16, "R8");                          // refused, then drain
    idle(2, "R9");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule